// File: doc/BRIEF.md
# Slave Data-Exchange Communication Watchdog

This block supervises the traffic a bus slave receives. Every time the slave gets a data-exchange call or a write-parameter call that was addressed to it and received without error, the supervision window restarts. If a whole window passes without such a call, the block raises a no-exchange status bit. That bit is meant to drive the diagnostic LED. The block can also ask the chip's reset generator for a full device reset.

The window is measured in ticks of an external 1 µs strobe. Its default length is 41000 ticks, which is 41 ms. Decoding, address matching, LED blink patterns and the reset generator itself sit outside the block; it receives ready-made single-cycle strobes for the two call types. The timer stays idle until the first qualifying call after reset. A slave that is never addressed therefore neither raises the status nor resets itself again and again.

The reset action can be enabled in two ways. A configuration flag enables it at all times. A second flag hands control to the level of parameter pin P0 while the first flag is clear. Whether the reset is enabled is decided in the cycle in which the window runs out.

Top module: `xchg_watchdog`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `no_xchg_status` and `reset_req` are both 0.
- R2: Before the first data-exchange or write-parameter strobe after reset, ticks have no effect: `no_xchg_status` and `reset_req` stay 0 however many ticks arrive.
- R3: After a qualifying strobe, with no further strobe, `no_xchg_status` goes to 1 in the cycle after the WINDOW_TICKS-th tick, counted from the strobe. Before that tick it is 0.
- R4: Either strobe type (`xchg_call_stb` or `param_call_stb`) restarts the window from zero. A strobe in the same cycle as what would have been the final tick wins, and no expiry happens.
- R5: Once set, `no_xchg_status` stays 1 until a qualifying strobe arrives. It reads 0 in the cycle after that strobe.
- R6: `reset_req` is a single-cycle pulse. It is high in the same cycle as the rising edge of `no_xchg_status`. It is issued at most once per expiry, and no further pulse occurs until a strobe rearms the timer and the window runs out again.
- R7: When `cfg_always_on` is 1, every expiry issues `reset_req`, whatever the values of `cfg_pin_ctrl` and `pin_p0`.
- R8: When `cfg_always_on` is 0 and `cfg_pin_ctrl` is 1, an expiry issues `reset_req` only if `pin_p0` is 1 in the cycle of the final tick. When both flags are 0, no reset is ever requested, and the status still rises.
- R9: Only cycles with `tick_1us` high advance the window. Cycles without a tick do not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_1us | input | 1 | One-cycle time-base strobe, nominally every 1 µs |
| xchg_call_stb | input | 1 | One-cycle strobe: addressed data-exchange call received |
| param_call_stb | input | 1 | One-cycle strobe: addressed write-parameter call received |
| cfg_always_on | input | 1 | Reset action permanently enabled |
| cfg_pin_ctrl | input | 1 | Reset action enabled by the level of `pin_p0` when `cfg_always_on` is 0 |
| pin_p0 | input | 1 | Parameter pin P0 level, active high enable |
| no_xchg_status | output | 1 | No-exchange status toward the diagnostic LED |
| reset_req | output | 1 | One-cycle device reset request |

## Verification
The bench walks every combination of the two configuration flags and the P0 level. This catches a design that lets the pin override a clear pin-control flag, or that ignores the pin entirely.

At the window boundary it checks the tick before expiry and the expiry tick itself. A counter off by one would raise the status one tick early or one tick late. It also places a strobe exactly on the final tick, where a design that gives expiry priority would fire anyway. Cycles without a tick are mixed in to expose a counter that runs on the clock instead of the tick.

After expiry, many more ticks pass. A design that rearms itself would pulse `reset_req` again, and one that holds the request would stretch the pulse. A long run with no call at all after reset shows a timer that was wrongly started from reset.

// File: rtl/xwd_pkg.sv
// Package: shared types for the data-exchange watchdog.
// Assumes: nothing beyond IEEE 1800-2017.
package xwd_pkg;

    // Supervision state: waiting for first call, timing a window, expired.
    typedef enum logic [1:0] {
        WD_IDLE    = 2'd0,
        WD_ARMED   = 2'd1,
        WD_EXPIRED = 2'd2
    } wd_state_e;

endpackage

// File: rtl/xwd_rearm.sv
// Module: xwd_rearm
// Merges the qualifying call strobes into one rearm request.
// Assumes: each strobe is already address-matched and one cycle wide.
module xwd_rearm #(
    parameter int unsigned N_SRC = 2
) (
    input  logic [N_SRC-1:0] call_stb,
    output logic             rearm
);

    // Any qualifying call source rearms the window.
    always_comb begin
        rearm = |call_stb;
    end

endmodule

// File: rtl/xwd_enable_sel.sv
// Module: xwd_enable_sel
// Decides whether an expiry may request a device reset.
// Assumes: the permanent flag has priority; pin control only counts when it is clear.
module xwd_enable_sel (
    input  logic cfg_always_on,
    input  logic cfg_pin_ctrl,
    input  logic pin_p0,
    output logic reset_en
);

    // Permanent enable first, otherwise pin-gated enable.
    always_comb begin
        if (cfg_always_on) begin
            reset_en = 1'b1;
        end else if (cfg_pin_ctrl) begin
            reset_en = pin_p0;
        end else begin
            reset_en = 1'b0;
        end
    end

endmodule

// File: rtl/xwd_window_timer.sv
// Module: xwd_window_timer
// Counts time-base ticks while armed and flags the final tick of a window.
// Assumes: rearm has priority over ticks; counting is held low when not armed.
module xwd_window_timer #(
    parameter int unsigned WINDOW_TICKS = 41000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic rearm,
    input  logic counting,
    output logic expire
);

    localparam int unsigned CNT_W = $clog2(WINDOW_TICKS + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WINDOW_TICKS - 1);

    logic [CNT_W-1:0] cnt_q;

    // Expiry: final tick of an armed window with no rearm in the same cycle.
    always_comb begin
        expire = counting && tick && !rearm && (cnt_q == LAST);
    end

    // Tick counter: cleared by rearm, advanced by ticks while armed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (rearm) begin
            cnt_q <= '0;
        end else if (counting && tick) begin
            cnt_q <= expire ? '0 : cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/xwd_status_ctl.sv
// Module: xwd_status_ctl
// Tracks supervision state, holds the status bit and forms the reset pulse.
// Assumes: expire is only raised while counting and never with rearm.
module xwd_status_ctl
    import xwd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rearm,
    input  logic expire,
    input  logic reset_en,
    output logic counting,
    output logic status,
    output logic reset_pulse
);

    wd_state_e state_q;
    wd_state_e state_d;
    logic      status_q;
    logic      pulse_q;

    // Next state: rearm always arms; expiry only leaves the armed state.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WD_IDLE:    if (rearm) state_d = WD_ARMED;
            WD_ARMED:   if (!rearm && expire) state_d = WD_EXPIRED;
            WD_EXPIRED: if (rearm) state_d = WD_ARMED;
            default:    state_d = WD_IDLE;
        endcase
    end

    // State, status and single-cycle reset request registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= WD_IDLE;
            status_q <= 1'b0;
            pulse_q  <= 1'b0;
        end else begin
            state_q  <= state_d;
            status_q <= (state_d == WD_EXPIRED);
            pulse_q  <= expire && reset_en;
        end
    end

    // Output mapping.
    always_comb begin
        counting    = (state_q == WD_ARMED);
        status      = status_q;
        reset_pulse = pulse_q;
    end

endmodule

// File: rtl/xchg_watchdog.sv
// Module: xchg_watchdog (top)
// Supervises addressed data-exchange and write-parameter calls, raises a
// no-exchange status after a silent window and optionally requests reset.
// Assumes: strobes and tick are one cycle wide and synchronous to clk.
module xchg_watchdog #(
    parameter int unsigned WINDOW_TICKS = 41000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_1us,
    input  logic xchg_call_stb,
    input  logic param_call_stb,
    input  logic cfg_always_on,
    input  logic cfg_pin_ctrl,
    input  logic pin_p0,
    output logic no_xchg_status,
    output logic reset_req
);

    logic rearm;
    logic reset_en;
    logic counting;
    logic expire;

    xwd_rearm #(.N_SRC(2)) u_rearm (
        .call_stb ({param_call_stb, xchg_call_stb}),
        .rearm    (rearm)
    );

    xwd_enable_sel u_en (
        .cfg_always_on (cfg_always_on),
        .cfg_pin_ctrl  (cfg_pin_ctrl),
        .pin_p0        (pin_p0),
        .reset_en      (reset_en)
    );

    xwd_window_timer #(.WINDOW_TICKS(WINDOW_TICKS)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_1us),
        .rearm    (rearm),
        .counting (counting),
        .expire   (expire)
    );

    xwd_status_ctl u_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .rearm       (rearm),
        .expire      (expire),
        .reset_en    (reset_en),
        .counting    (counting),
        .status      (no_xchg_status),
        .reset_pulse (reset_req)
    );

endmodule

// File: rtl/xwd_checker.sv
// Module: xwd_checker
// Temporal properties of the watchdog, observed at its ports.
// Assumes: bound to xchg_watchdog.
module xwd_checker (
    input logic clk,
    input logic rst_n,
    input logic tick_1us,
    input logic xchg_call_stb,
    input logic param_call_stb,
    input logic cfg_always_on,
    input logic cfg_pin_ctrl,
    input logic pin_p0,
    input logic no_xchg_status,
    input logic reset_req
);

    // R6
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |=> !reset_req);

    // R6
    pulse_with_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |-> $rose(no_xchg_status));

    // R5
    status_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xchg_call_stb || param_call_stb) |=> !no_xchg_status);

    // R5
    status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (no_xchg_status && !xchg_call_stb && !param_call_stb) |=> no_xchg_status);

    // R9
    rise_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(no_xchg_status) |-> $past(tick_1us));

    // R8
    pin_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_always_on && !cfg_pin_ctrl) |=> !reset_req);

endmodule

bind xchg_watchdog xwd_checker u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .tick_1us       (tick_1us),
    .xchg_call_stb  (xchg_call_stb),
    .param_call_stb (param_call_stb),
    .cfg_always_on  (cfg_always_on),
    .cfg_pin_ctrl   (cfg_pin_ctrl),
    .pin_p0         (pin_p0),
    .no_xchg_status (no_xchg_status),
    .reset_req      (reset_req)
);

// File: tb/xchg_watchdog_tb.sv
module xchg_watchdog_tb;

    localparam int W = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_1us = 1'b0;
    logic xchg_call_stb = 1'b0;
    logic param_call_stb = 1'b0;
    logic cfg_always_on = 1'b0;
    logic cfg_pin_ctrl = 1'b0;
    logic pin_p0 = 1'b0;
    logic no_xchg_status;
    logic reset_req;

    int n_chk = 0;
    int n_bad = 0;
    int pulses = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    xchg_watchdog #(.WINDOW_TICKS(W)) u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .tick_1us       (tick_1us),
        .xchg_call_stb  (xchg_call_stb),
        .param_call_stb (param_call_stb),
        .cfg_always_on  (cfg_always_on),
        .cfg_pin_ctrl   (cfg_pin_ctrl),
        .pin_p0         (pin_p0),
        .no_xchg_status (no_xchg_status),
        .reset_req      (reset_req)
    );

    // {always_on, pin_ctrl, p0, expected reset request}
    localparam logic [3:0] VEC [8] = '{
        4'b0000, 4'b0010, 4'b0100, 4'b0111,
        4'b1001, 4'b1011, 4'b1101, 4'b1111
    };

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic chk_int(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(input logic t, input logic dx, input logic pw);
        @(negedge clk);
        tick_1us = t;
        xchg_call_stb = dx;
        param_call_stb = pw;
        @(posedge clk);
        #1;
        if (reset_req) pulses++;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        tick_1us = 1'b0;
        xchg_call_stb = 1'b0;
        param_call_stb = 1'b0;
        @(posedge clk);
        @(posedge clk);
        #1;
        @(negedge clk);
        rst_n = 1'b1;
        pulses = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #400000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R1: reset state
        do_reset();
        chk("R1 status in reset", no_xchg_status, 1'b0);
        chk("R1 reset_req in reset", reset_req, 1'b0);
        cyc(1'b0, 1'b0, 1'b0);
        chk("R1 status after reset", no_xchg_status, 1'b0);

        // R2: ticks before first call do nothing
        for (int i = 0; i < 3 * W; i++) cyc(1'b1, 1'b0, 1'b0);
        chk("R2 no status before first call", no_xchg_status, 1'b0);
        chk_int("R2 no reset before first call", pulses, 0);

        // Table walk: R3, R7, R8
        for (int v = 0; v < 8; v++) begin
            do_reset();
            cfg_always_on = VEC[v][3];
            cfg_pin_ctrl  = VEC[v][2];
            pin_p0        = VEC[v][1];
            cyc(1'b0, v[0], !v[0]);
            for (int i = 0; i < W - 1; i++) cyc(1'b1, 1'b0, 1'b0);
            chk("R3 status before final tick", no_xchg_status, 1'b0);
            cyc(1'b1, 1'b0, 1'b0);
            chk("R3 status on final tick", no_xchg_status, 1'b1);
            chk("R7/R8 reset_req per enable", reset_req, VEC[v][0]);
            cyc(1'b0, 1'b0, 1'b0);
            chk("R6 pulse one cycle", reset_req, 1'b0);
        end

        // R4: strobe coincident with final tick restarts the window
        cfg_always_on = 1'b1;
        do_reset();
        cyc(1'b0, 1'b1, 1'b0);
        for (int i = 0; i < W - 1; i++) cyc(1'b1, 1'b0, 1'b0);
        cyc(1'b1, 1'b0, 1'b1);
        chk("R4 strobe on final tick wins", no_xchg_status, 1'b0);
        for (int i = 0; i < W - 1; i++) cyc(1'b1, 1'b0, 1'b0);
        chk("R4 restarted window not yet over", no_xchg_status, 1'b0);
        cyc(1'b1, 1'b0, 1'b0);
        chk("R4 restarted window expires", no_xchg_status, 1'b1);

        // R6: only one pulse per expiry; R5: status holds
        for (int i = 0; i < 3 * W; i++) cyc(1'b1, 1'b0, 1'b0);
        chk_int("R6 single pulse per expiry", pulses, 1);
        chk("R5 status holds without call", no_xchg_status, 1'b1);

        // R5: call clears status
        cyc(1'b0, 1'b1, 1'b0);
        chk("R5 status cleared by call", no_xchg_status, 1'b0);

        // R9: non-tick cycles do not advance
        for (int i = 0; i < W - 1; i++) begin
            cyc(1'b1, 1'b0, 1'b0);
            cyc(1'b0, 1'b0, 1'b0);
            cyc(1'b0, 1'b0, 1'b0);
        end
        chk("R9 idle cycles not counted", no_xchg_status, 1'b0);
        cyc(1'b1, 1'b0, 1'b0);
        chk("R9 expiry on tick count", no_xchg_status, 1'b1);
        chk_int("R6 second expiry pulses again", pulses, 2);

        // R8: pin level sampled at expiry, pin low blocks reset
        cfg_always_on = 1'b0;
        cfg_pin_ctrl = 1'b1;
        pin_p0 = 1'b1;
        cyc(1'b0, 1'b0, 1'b1);
        for (int i = 0; i < W - 1; i++) cyc(1'b1, 1'b0, 1'b0);
        pin_p0 = 1'b0;
        cyc(1'b1, 1'b0, 1'b0);
        chk("R8 pin low at expiry blocks reset", reset_req, 1'b0);
        chk("R8 status still rises", no_xchg_status, 1'b1);

        finish_run();
    end

endmodule